// File: doc/BRIEF.md
# Sigma-Delta Channel Bit Receiver

This block is the input stage of one sigma-delta modulator channel. It watches a serial data pin and a serial clock pin, both sampled on the system clock, and recovers the modulator bitstream. Each recovered bit appears on `bit_out`, together with a `bit_vld` strobe that is one system clock long. A decimation filter downstream takes these strobes. The bitstream can arrive in a clocked serial form, sampled on either clock edge. It can also arrive Manchester coded with no clock, in which case the block recovers it from the data pin alone by timing transitions in system clocks.

In the clocked forms there are four choices for the serial clock. It can be the external clock pin or the internal clock-out signal used as it is. It can also be a copy of the internal clock halved inside the block, toggling on either the falling edges or the rising edges of that clock. A select input can take the data from the neighbouring channel's pin instead of this channel's own pin. A channel enable gates everything.

All pins pass through two synchronising flip-flops. The system clock must run at least four times the serial bit rate. In Manchester mode it must also match the `HALF_CYC` parameter, which is the number of system clocks in half a bit.

Top module: `sdm_bit_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `bit_vld` and `bit_out` are 0 after that edge, and the halved clock is cleared to low.
- R2: With `if_type` = 2'b00, a bit is taken on each rising edge of the selected serial clock. `bit_vld` is high after the third system clock edge that follows the edge on the clock pin, and `bit_out` then equals the data pin level present at that clock pin edge.
- R3: With `if_type` = 2'b01, bits are taken on falling edges of the selected serial clock, with the same timing as R2.
- R4: With `if_type` = 2'b10 (Manchester), a rising mid-bit transition on the data pin yields bit 0 and a falling one yields bit 1.
- R5: With `if_type` = 2'b11 (Manchester, inverted), a rising mid-bit transition yields bit 1 and a falling one yields bit 0.
- R6: In Manchester mode, a data transition is taken as a mid-bit transition only if at least WIN = HALF_CYC + HALF_CYC/2 system clocks have passed since the last accepted one, or since enable. Earlier transitions, such as those at bit boundaries, are ignored. The strobe follows an accepted transition on the pin after three clock edges.
- R7: `clk_src` = 0 takes the serial clock from `ext_clk`, and `clk_src` = 1 takes it from `int_clk` unchanged.
- R8: `clk_src` = 2 uses `int_clk` halved, toggling on each falling edge of `int_clk`. `clk_src` = 3 uses it halved, toggling on each rising edge. The halved clock is low at enable. The strobe comes one clock later than in R2, after the fourth edge.
- R9: `alt_sel` = 1 takes the serial data from `data_nbr`, and `alt_sel` = 0 takes it from `data_own`. The unselected pin has no effect.
- R10: While `ch_en` is low, no strobe is produced, and both the halved clock and the Manchester window are cleared.
- R11: Every `bit_vld` pulse lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 1 | Channel enable |
| if_type | input | 2 | Interface type: 0 clocked/rising, 1 clocked/falling, 2 Manchester, 3 Manchester inverted |
| clk_src | input | 2 | Serial clock source: 0 external pin, 1 internal, 2 internal halved on falling, 3 internal halved on rising |
| alt_sel | input | 1 | Take data from the neighbouring pin |
| data_own | input | 1 | This channel's data pin |
| data_nbr | input | 1 | Neighbouring channel's data pin |
| ext_clk | input | 1 | External serial clock pin |
| int_clk | input | 1 | Internal clock-out signal |
| bit_out | output | 1 | Recovered bit |
| bit_vld | output | 1 | One-clock strobe marking a new bit |

## Verification
A clock or data edge on a pin reaches `bit_vld` after the third rising system clock edge: two synchroniser stages and one output register. A halved clock source adds its toggle register, so the strobe comes after the fourth edge. The bench changes pins just after a falling edge and reads outputs only on falling edges. Its latency tests count those falling edges to check that the strobe is absent before the due edge, present after it, and gone one edge later. The vector tests hold the data long enough around every serial clock edge that only the bit count and the bit values are compared.

// File: rtl/sdm_rx_pkg.sv
// Shared types for the sigma-delta channel bit receiver.
// Assumes the encodings below are fixed by the register that drives them.
package sdm_rx_pkg;

    // number of flip-flops on every incoming pin
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        IF_CLK_RISE  = 2'd0,
        IF_CLK_FALL  = 2'd1,
        IF_MAN_RISE0 = 2'd2,
        IF_MAN_RISE1 = 2'd3
    } if_type_e;

    typedef enum logic [1:0] {
        CK_PIN        = 2'd0,
        CK_INT        = 2'd1,
        CK_INT_HALF_F = 2'd2,
        CK_INT_HALF_R = 2'd3
    } ck_src_e;

endpackage

// File: rtl/sdm_pin_sync.sv
// Multi-flop synchroniser for a group of asynchronous pins.
// Assumes DEPTH >= 2; every pin gets the same delay so pins stay aligned.
module sdm_pin_sync #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);

    logic [DEPTH-1:0][WIDTH-1:0] stage;

    // shift the pin group through DEPTH flip-flop stages
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[DEPTH-2:0], pin_i};
    end

    assign pin_o = stage[DEPTH-1];

endmodule

// File: rtl/sdm_clk_pick.sv
// Chooses the serial clock level: external pin, internal clock, or the
// internal clock halved by a toggle flop stepped on a chosen edge.
// Assumes synchronised inputs; the halved level is itself registered.
module sdm_clk_pick
    import sdm_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    ext_s,
    input  logic    int_s,
    input  ck_src_e src,
    output logic    sclk
);

    logic int_q;
    logic half;
    logic int_rise;
    logic int_fall;
    logic half_step;

    assign int_rise = int_s & ~int_q;
    assign int_fall = ~int_s & int_q;

    // previous internal clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= int_s;
    end

    // which internal edge steps the halved clock
    always_comb begin
        case (src)
            CK_INT_HALF_F: half_step = int_fall;
            CK_INT_HALF_R: half_step = int_rise;
            default:       half_step = 1'b0;
        endcase
    end

    // halved clock toggle, cleared while the channel is off
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  half <= 1'b0;
        else if (half_step) half <= ~half;
    end

    // serial clock source multiplexer
    always_comb begin
        case (src)
            CK_PIN:  sclk = ext_s;
            CK_INT:  sclk = int_s;
            default: sclk = half;
        endcase
    end

endmodule

// File: rtl/sdm_clk_capture.sv
// Clocked serial capture: samples data on the chosen edge of the serial
// clock level, detected on the system clock. Assumes sclk and din are
// synchronous to clk and aligned in delay.
module sdm_clk_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic on_fall,
    input  logic sclk,
    input  logic din,
    output logic bit_q,
    output logic vld_q
);

    logic sclk_q;
    logic hit;

    assign hit = on_fall ? (sclk_q & ~sclk) : (sclk & ~sclk_q);

    // track the serial clock even when disabled, so enable makes no false edge
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // register the sampled bit and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= en & hit;
            if (hit) bit_q <= din;
        end
    end

endmodule

// File: rtl/sdm_manch_dec.sv
// Manchester decoder by oversampling. A transition counts as mid-bit once
// WIN clocks have passed since the last accepted one; boundary transitions
// fall inside the window and are dropped. Assumes HALF_CYC >= 2.
module sdm_manch_dec #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rise_is_one,
    input  logic din,
    output logic bit_q,
    output logic vld_q
);

    localparam int WIN = HALF_CYC + HALF_CYC / 2;
    localparam int CW  = $clog2(WIN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(WIN);

    logic          din_q;
    logic [CW-1:0] since;
    logic          open_win;
    logic          accept;

    assign open_win = (since == CNT_TOP);
    assign accept   = (din ^ din_q) & open_win;

    // previous data level for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    // clocks since last accepted transition, saturating at the window
    always_ff @(posedge clk) begin
        if (!rst_n || !en)     since <= CNT_TOP;
        else if (accept)       since <= '0;
        else if (!open_win)    since <= since + 1'b1;
    end

    // decoded bit and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= en & accept;
            if (accept) bit_q <= rise_is_one ? din : ~din;
        end
    end

endmodule

// File: rtl/sdm_bit_rx.sv
// Sigma-delta channel bit receiver top. Synchronises the pins, picks the
// data pin and serial clock, and runs either the clocked capture or the
// Manchester decoder. Assumes clk is at least four times the bit rate.
module sdm_bit_rx
    import sdm_rx_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ch_en,
    input  logic [1:0] if_type,
    input  logic [1:0] clk_src,
    input  logic       alt_sel,
    input  logic       data_own,
    input  logic       data_nbr,
    input  logic       ext_clk,
    input  logic       int_clk,
    output logic       bit_out,
    output logic       bit_vld
);

    localparam int N_PINS = 4;

    if_type_e          kind;
    ck_src_e           src;
    logic [N_PINS-1:0] pins_s;
    logic              din;
    logic              sclk;
    logic              c_bit, c_vld;
    logic              m_bit, m_vld;

    assign kind = if_type_e'(if_type);
    assign src  = ck_src_e'(clk_src);

    sdm_pin_sync #(.WIDTH(N_PINS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({int_clk, ext_clk, data_nbr, data_own}),
        .pin_o (pins_s)
    );

    assign din = alt_sel ? pins_s[1] : pins_s[0];

    sdm_clk_pick u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ch_en),
        .ext_s (pins_s[2]),
        .int_s (pins_s[3]),
        .src   (src),
        .sclk  (sclk)
    );

    sdm_clk_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ch_en & (kind inside {IF_CLK_RISE, IF_CLK_FALL})),
        .on_fall (kind == IF_CLK_FALL),
        .sclk    (sclk),
        .din     (din),
        .bit_q   (c_bit),
        .vld_q   (c_vld)
    );

    sdm_manch_dec #(.HALF_CYC(HALF_CYC)) u_man (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ch_en & (kind inside {IF_MAN_RISE0, IF_MAN_RISE1})),
        .rise_is_one (kind == IF_MAN_RISE1),
        .din         (din),
        .bit_q       (m_bit),
        .vld_q       (m_vld)
    );

    // output follows the decoder family chosen by the interface type
    always_comb begin
        if (if_type[1]) begin
            bit_out = m_bit;
            bit_vld = m_vld;
        end else begin
            bit_out = c_bit;
            bit_vld = c_vld;
        end
    end

endmodule

// File: rtl/sdm_bit_rx_chk.sv
// Property checker for sdm_bit_rx, attached by bind. Assumes two sync
// stages, so a pin reaches a strobed output three clocks later.
module sdm_bit_rx_chk #(
    parameter int HALF_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ch_en,
    input logic [1:0] if_type,
    input logic       alt_sel,
    input logic       data_own,
    input logic       data_nbr,
    input logic       bit_out,
    input logic       bit_vld
);

    localparam int WIN = HALF_CYC + HALF_CYC / 2;
    localparam int GW  = $clog2(WIN + 1);
    localparam logic [GW-1:0] GAP_TOP = GW'(WIN);

    logic [1:0]    type_q;
    logic [GW-1:0] gap;

    // remember the previous interface type
    always_ff @(posedge clk) begin
        if (!rst_n) type_q <= 2'd0;
        else        type_q <= if_type;
    end

    // clocks since the last Manchester strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !ch_en || !if_type[1] || (if_type != type_q)) gap <= GAP_TOP;
        else if (bit_vld)                                          gap <= '0;
        else if (gap != GAP_TOP)                                   gap <= gap + 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bit_vld && !bit_out));

    a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> !bit_vld);

    a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> (!bit_vld || !$stable(if_type)));

    // R9 with R2/R3: clocked bit equals the selected pin three clocks back
    a_r9_clocked_data_path: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !if_type[1] && $stable(if_type)) |->
        (bit_out == ($past(alt_sel) ? $past(data_nbr, 3) : $past(data_own, 3))));

    // R4 and R5: decoded value follows the transition polarity
    a_r4_manch_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && if_type[1] && $stable(if_type)) |->
        (bit_out == (if_type[0] ~^ ($past(alt_sel) ? $past(data_nbr, 3) : $past(data_own, 3)))));

    a_r6_window_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && if_type[1] && $stable(if_type) && ch_en) |-> (gap >= GAP_TOP));

endmodule

bind sdm_bit_rx sdm_bit_rx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .if_type  (if_type),
    .alt_sel  (alt_sel),
    .data_own (data_own),
    .data_nbr (data_nbr),
    .bit_out  (bit_out),
    .bit_vld  (bit_vld)
);

// File: tb/test_sdm_bit_rx.sv
module test_sdm_bit_rx;

    localparam int HALF = 4;
    localparam int NV   = 11;

    // {if_type[1:0], clk_src[1:0], alt_sel, pattern[7:0]}; patterns 00/FF also cover R6
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b0, 8'hA5},
        {2'd1, 2'd0, 1'b0, 8'h3C},
        {2'd0, 2'd1, 1'b1, 8'h96},
        {2'd1, 2'd1, 1'b0, 8'hF0},
        {2'd0, 2'd2, 1'b0, 8'h5A},
        {2'd1, 2'd3, 1'b1, 8'hC3},
        {2'd0, 2'd3, 1'b0, 8'h81},
        {2'd2, 2'd0, 1'b0, 8'hB2},
        {2'd3, 2'd0, 1'b1, 8'h4D},
        {2'd2, 2'd0, 1'b1, 8'h00},
        {2'd3, 2'd0, 1'b0, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ch_en = 1'b0;
    logic [1:0] if_type = 2'd0;
    logic [1:0] clk_src = 2'd0;
    logic       alt_sel = 1'b0;
    logic       data_own = 1'b0;
    logic       data_nbr = 1'b0;
    logic       ext_clk = 1'b0;
    logic       int_clk = 1'b0;
    logic       bit_out;
    logic       bit_vld;

    int          checks = 0;
    int          errors = 0;
    int          n_strb = 0;
    logic [63:0] got = '0;

    sdm_bit_rx #(.HALF_CYC(HALF)) i_sdm_bit_rx (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .if_type(if_type),
        .clk_src(clk_src), .alt_sel(alt_sel), .data_own(data_own),
        .data_nbr(data_nbr), .ext_clk(ext_clk), .int_clk(int_clk),
        .bit_out(bit_out), .bit_vld(bit_vld)
    );

    always #5 clk = ~clk;

    // collect strobed bits away from the active edge
    always @(negedge clk) begin
        if (bit_vld) begin
            n_strb <= n_strb + 1;
            got    <= {got[62:0], bit_out};
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_data(input logic v, input logic alt);
        if (alt) begin data_nbr = v; data_own = ~v; end
        else     begin data_own = v; data_nbr = ~v; end
    endtask

    task automatic drive_clk(input logic [1:0] sel, input logic lvl);
        if (sel == 2'd0) ext_clk = lvl;
        else             int_clk = lvl;
    endtask

    task automatic run_vec(input logic [12:0] v);
        logic [1:0] md;
        logic [1:0] sel;
        logic       alt;
        logic [7:0] pat;
        logic       idle;
        logic       fh;
        int         npulse;
        int         base;
        string      tag;
        md  = v[12:11];
        sel = v[10:9];
        alt = v[8];
        pat = v[7:0];
        case (md)
            2'd0: tag = "R2";
            2'd1: tag = "R3";
            2'd2: tag = "R4 R6";
            default: tag = "R5 R6";
        endcase
        tag = {tag, (sel[1] ? " R8" : " R7"), (alt ? " R9" : "")};
        ch_en   = 1'b0;
        if_type = md;
        clk_src = sel;
        alt_sel = alt;
        idle    = (!sel[1] && md == 2'd1);
        npulse  = sel[1] ? 2 : 1;
        ext_clk = idle;
        int_clk = idle;
        fh      = (md == 2'd2) ? pat[7] : ~pat[7];
        set_data(md[1] ? fh : 1'b0, alt);
        wait_n(6);
        base  = n_strb;
        ch_en = 1'b1;
        wait_n(2);
        for (int i = 7; i >= 0; i--) begin
            if (md[1]) begin
                fh = (md == 2'd2) ? pat[i] : ~pat[i];
                set_data(fh, alt);
                wait_n(HALF);
                set_data(~fh, alt);
                wait_n(HALF);
            end else begin
                set_data(pat[i], alt);
                wait_n(3);
                for (int p = 0; p < npulse; p++) begin
                    drive_clk(sel, ~idle);
                    wait_n(3);
                    drive_clk(sel, idle);
                    wait_n(3);
                end
            end
        end
        wait_n(6);
        check({tag, " count"}, 64'(n_strb - base), 64'd8);
        check({tag, " bits"}, {56'd0, got[7:0]}, {56'd0, pat});
        ch_en = 1'b0;
        wait_n(2);
    endtask

    initial begin
        int base;
        wait_n(5);
        check("R1 vld at reset", {63'd0, bit_vld}, 64'd0);
        check("R1 bit at reset", {63'd0, bit_out}, 64'd0);
        rst_n = 1'b1;
        wait_n(4);

        foreach (VEC[k]) run_vec(VEC[k]);

        // R2 and R11: strobe after third edge, one clock wide
        if_type = 2'd0; clk_src = 2'd0; alt_sel = 1'b0;
        ext_clk = 1'b0; set_data(1'b1, 1'b0);
        wait_n(5);
        ch_en = 1'b1;
        wait_n(3);
        ext_clk = 1'b1;
        wait_n(2);
        check("R2 no strobe before third edge", {63'd0, bit_vld}, 64'd0);
        wait_n(1);
        check("R2 strobe after third edge", {63'd0, bit_vld}, 64'd1);
        check("R2 bit value", {63'd0, bit_out}, 64'd1);
        wait_n(1);
        check("R11 strobe one clock wide", {63'd0, bit_vld}, 64'd0);
        ext_clk = 1'b0;
        wait_n(5);
        ch_en = 1'b0;

        // R8: halved source adds one clock
        clk_src = 2'd2; int_clk = 1'b0;
        wait_n(4);
        ch_en = 1'b1;
        wait_n(3);
        int_clk = 1'b1;
        wait_n(6);
        check("R8 no strobe on rising int with falling step", {63'd0, bit_vld}, 64'd0);
        int_clk = 1'b0;
        wait_n(3);
        check("R8 no strobe after third edge", {63'd0, bit_vld}, 64'd0);
        wait_n(1);
        check("R8 strobe after fourth edge", {63'd0, bit_vld}, 64'd1);
        wait_n(4);
        ch_en = 1'b0;

        // R10: clock pulses while disabled produce nothing
        clk_src = 2'd0; ext_clk = 1'b0;
        wait_n(4);
        base = n_strb;
        for (int p = 0; p < 4; p++) begin
            set_data(p[0], 1'b0);
            wait_n(3);
            ext_clk = 1'b1;
            wait_n(3);
            ext_clk = 1'b0;
            wait_n(3);
        end
        wait_n(5);
        check("R10 no strobes when disabled", 64'(n_strb - base), 64'd0);

        // R6: early transition ignored, later one accepted
        if_type = 2'd2; set_data(1'b0, 1'b0);
        wait_n(5);
        ch_en = 1'b1;
        wait_n(3);
        base = n_strb;
        data_own = 1'b1;
        wait_n(3);
        data_own = 1'b0;
        wait_n(20);
        check("R6 early transition ignored", 64'(n_strb - base), 64'd1);
        check("R6 first transition bit", {63'd0, got[0]}, 64'd0);
        data_own = 1'b1;
        wait_n(10);
        check("R6 transition after window accepted", 64'(n_strb - base), 64'd2);
        check("R4 rising gives zero", {63'd0, got[0]}, 64'd0);
        ch_en = 1'b0;
        wait_n(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule